// File: doc/BRIEF.md
# Self-Testing Scan Wrapper with Pattern Generator and Signature Compaction

This block turns a core that was built to be tested with externally applied scan vectors into one that tests itself. Two small registers surround the core's own scan chain. An input-source register sits in front of it and drives the core's primary inputs. An output-capture register sits behind it and samples the core's primary outputs. Together with the core chain they form one extended serial chain. A pseudo-random generator feeds that chain, and a serial signature register compacts everything that falls out of its far end.

A run begins with a start pulse. The wrapper first fills the chain. It then alternates one capture cycle, with the core's scan-enable low, with a full-length shift. That shift unloads the previous response while it loads the next stimulus. After the last capture, a final drain shift empties the chain and the block reports done. The signature is then compared with a golden value. The ones-density of the stimulus can be biased to about one quarter or three quarters. The bias may be changed between patterns while the run is in progress, which helps reach faults that resist plain random patterns.

The sequencer walks through six named states. IDLE leaves on start to FILL. FILL, after L shift cycles, goes to CAPT. CAPT goes to DRAIN after the last pattern and to SWAP otherwise. SWAP, after L shift cycles, returns to CAPT. DRAIN, after L shift cycles, goes to DONE. DONE leaves on start to FILL.

Top module: `scan_selftest_wrap`

## Requirements
- R1: The extended chain has length L = PI_W + CORE_LEN + PO_W. The generator bit enters the input-source register at its MSB, and that register shifts toward bit 0. Its bit 0 drives core_si, and its full contents drive core_pi. core_so enters the output-capture register at its MSB, and that register's bit 0 feeds the signature register.
- R2: A start accepted in IDLE or DONE gives L fill shift cycles, then NUM_PAT capture cycles with L shift cycles between successive captures, then L drain shift cycles. done rises NUM_PAT*(L+1)+L clock cycles after the edge that accepted start.
- R3: Each capture lasts exactly one cycle with core_se low. In that cycle the output-capture register loads core_po and the input-source register holds its value. core_se is high in every shift cycle and low in IDLE and DONE.
- R4: The generator is a 16-bit left-shifting Fibonacci LFSR. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. It is reseeded to 16'hACE1 on start and advances once per shift cycle. The output bit is chosen by the weight code: 00 or 11 gives bit 15; 01 gives bit15 AND bit7 (about 0.25 ones); 10 gives bit15 OR bit7 (about 0.75 ones).
- R5: weight_mode is sampled on the edge that accepts start and on the edge that ends each capture cycle. The sampled code governs all shift cycles until the next sample.
- R6: The signature is cleared on start. In every SWAP and DRAIN shift cycle it takes the output-capture bit 0 as b, and with fb = sig[15]^b it becomes {sig[14:0],0} XOR (fb ? 16'h1021 : 0). Shifts during FILL are not compacted.
- R7: done stays high and the signature stays unchanged until the next start. pass is high only when done is high and the signature equals the GOLDEN parameter.
- R8: start has no effect while busy is high.
- R9: After reset, busy, done, pass and core_se are 0, the signature is 0 and core_pi is 0.
- R10: busy is high from the cycle after an accepted start until done rises, and busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a self-test run when idle or done |
| weight_mode | input | 2 | Stimulus bias code: 00/11 plain, 01 low, 10 high |
| core_pi | output | PI_W | Primary-input values for the core, from the input-source register |
| core_po | input | PO_W | Primary outputs of the core |
| core_se | output | 1 | Scan-enable to the core |
| core_si | output | 1 | Serial data into the core chain |
| core_so | input | 1 | Serial data out of the core chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, signature final |
| signature | output | 16 | Compacted response |
| pass | output | 1 | Final signature equals GOLDEN |

## Verification
In every SWAP cycle the response of one pattern is unloaded and compacted while the stimulus of the next pattern is loaded and the generator advances. The cycle that ends a capture also samples a new weight code. The bench provokes both overlaps by changing the weight code at each capture. In one run it also pulses start in the middle. It judges the result by comparing the final signature, the contents of the input-source register and the run length with a bit-serial model of the whole chain. That model is built from the stated polynomials and a toy core.

// File: rtl/scan_bist_pkg.sv
package scan_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_CAPT  = 3'd2,
        ST_SWAP  = 3'd3,
        ST_DRAIN = 3'd4,
        ST_DONE  = 3'd5
    } bist_state_e;

    typedef enum logic [1:0] {
        WT_PLAIN     = 2'd0,
        WT_LOW       = 2'd1,
        WT_HIGH      = 2'd2,
        WT_PLAIN_ALT = 2'd3
    } weight_e;

    localparam int          SIG_W    = 16;
    localparam logic [15:0] SIG_POLY = 16'h1021;
    localparam logic [15:0] GEN_TAPS = 16'hB400;

endpackage

// File: rtl/bist_seq.sv
module bist_seq
    import scan_bist_pkg::*;
#(
    parameter int CHAIN_LEN = 13,
    parameter int NUM_PAT   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic shift_en,
    output logic capture_en,
    output logic compact_en,
    output logic busy,
    output logic done
);

    localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam int PW = $clog2(NUM_PAT + 1);

    bist_state_e    state_q, state_d;
    logic [CW-1:0]  bit_cnt;
    logic [PW-1:0]  pat_cnt;
    logic           last_bit, last_pat;

    assign last_bit = (bit_cnt == CW'(CHAIN_LEN - 1));
    assign last_pat = (pat_cnt == PW'(NUM_PAT - 1));
    assign accept   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_FILL;
            ST_FILL:  if (last_bit) state_d = ST_CAPT;
            ST_CAPT:  state_d = last_pat ? ST_DRAIN : ST_SWAP;
            ST_SWAP:  if (last_bit) state_d = ST_CAPT;
            ST_DRAIN: if (last_bit) state_d = ST_DONE;
            ST_DONE:  if (start)    state_d = ST_FILL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // bit and pattern counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            pat_cnt <= '0;
        end else if (accept) begin
            bit_cnt <= '0;
            pat_cnt <= '0;
        end else if (shift_en) begin
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        end else if (capture_en) begin
            bit_cnt <= '0;
            pat_cnt <= pat_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        shift_en   = 1'b0;
        capture_en = 1'b0;
        compact_en = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FILL:  begin shift_en = 1'b1; busy = 1'b1; end
            ST_CAPT:  begin capture_en = 1'b1; busy = 1'b1; end
            ST_SWAP:  begin shift_en = 1'b1; compact_en = 1'b1; busy = 1'b1; end
            ST_DRAIN: begin shift_en = 1'b1; compact_en = 1'b1; busy = 1'b1; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(CHAIN_LEN - 1));

    p_patcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pat_cnt <= PW'(NUM_PAT));

    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

// File: rtl/bist_pgen.sv
module bist_pgen
    import scan_bist_pkg::*;
#(
    parameter int          W      = 16,
    parameter logic [W-1:0] TAPS  = 16'hB400,
    parameter logic [W-1:0] SEED  = 16'hACE1,
    parameter int          WT_TAP = 7
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    reseed,
    input  logic    step,
    input  logic    wload,
    input  weight_e wsel,
    output logic    bit_out
);

    logic [W-1:0] lfsr;
    weight_e      wt_q;
    logic         fb;

    assign fb = ^(lfsr & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lfsr <= SEED;
        else if (reseed) lfsr <= SEED;
        else if (step)   lfsr <= {lfsr[W-2:0], fb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wt_q <= WT_PLAIN;
        else if (wload) wt_q <= wsel;
    end

    always_comb begin
        unique case (wt_q)
            WT_LOW:  bit_out = lfsr[W-1] & lfsr[WT_TAP];
            WT_HIGH: bit_out = lfsr[W-1] | lfsr[WT_TAP];
            default: bit_out = lfsr[W-1];
        endcase
    end

    p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

    p_lfsr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !reseed) |=> $stable(lfsr));

endmodule

// File: rtl/bist_shreg.sv
module bist_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         cap,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q,
    output logic         ser_out
);

    assign ser_out = q[0];

    generate
        if (W == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= ser_in;
                else if (cap)   q <= par_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= {ser_in, q[W-1:1]};
                else if (cap)   q <= par_in;
            end
        end
    endgenerate

endmodule

// File: rtl/bist_sig.sv
module bist_sig #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] sig
);

    logic fb;
    assign fb = sig[W-1] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sig <= '0;
        else if (clear) sig <= '0;
        else if (en)    sig <= {sig[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    p_sig_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sig == '0));

    p_sig_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(sig));

endmodule

// File: rtl/scan_selftest_wrap.sv
module scan_selftest_wrap
    import scan_bist_pkg::*;
#(
    parameter int          PI_W     = 4,
    parameter int          PO_W     = 3,
    parameter int          CORE_LEN = 6,
    parameter int          NUM_PAT  = 8,
    parameter logic [15:0] GEN_SEED = 16'hACE1,
    parameter logic [15:0] GOLDEN   = 16'h0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      weight_mode,
    output logic [PI_W-1:0] core_pi,
    input  logic [PO_W-1:0] core_po,
    output logic            core_se,
    output logic            core_si,
    input  logic            core_so,
    output logic            busy,
    output logic            done,
    output logic [15:0]     signature,
    output logic            pass
);

    localparam int CHAIN_LEN = PI_W + CORE_LEN + PO_W;

    logic            accept, shift_en, capture_en, compact_en;
    logic            gen_bit, ro_out;
    logic [PO_W-1:0] ro_q;

    bist_seq #(
        .CHAIN_LEN (CHAIN_LEN),
        .NUM_PAT   (NUM_PAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .accept     (accept),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .compact_en (compact_en),
        .busy       (busy),
        .done       (done)
    );

    bist_pgen #(
        .W      (16),
        .TAPS   (GEN_TAPS),
        .SEED   (GEN_SEED),
        .WT_TAP (7)
    ) u_pgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (accept),
        .step    (shift_en),
        .wload   (accept || capture_en),
        .wsel    (weight_e'(weight_mode)),
        .bit_out (gen_bit)
    );

    // input-source register: head of the extended chain
    bist_shreg #(.W(PI_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (shift_en),
        .cap     (1'b0),
        .ser_in  (gen_bit),
        .par_in  ('0),
        .q       (core_pi),
        .ser_out (core_si)
    );

    // output-capture register: tail of the extended chain
    bist_shreg #(.W(PO_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (shift_en),
        .cap     (capture_en),
        .ser_in  (core_so),
        .par_in  (core_po),
        .q       (ro_q),
        .ser_out (ro_out)
    );

    bist_sig #(
        .W    (SIG_W),
        .POLY (SIG_POLY)
    ) u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (compact_en),
        .din   (ro_out),
        .sig   (signature)
    );

    assign core_se = shift_en;
    assign pass    = done && (signature == GOLDEN);

    p_capture_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_se) |=> core_se);

    p_ro_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_se) |=> (ro_q == $past(core_po)));

    p_pi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_se) |=> $stable(core_pi));

    p_done_after_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(core_se));

    p_pass_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    p_sig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(signature)));

endmodule

// File: tb/scan_selftest_wrap_test.sv
`timescale 1ns/1ps

package toy_core_pkg;
    function automatic logic [5:0] core_next(input logic [3:0] pi, input logic [5:0] st);
        return {st[4:0], st[5] ^ pi[0]} ^ {pi[3:1], 3'b000};
    endfunction
    function automatic logic [2:0] core_out(input logic [3:0] pi, input logic [5:0] st);
        return {st[5] & pi[3], st[3] | pi[1], st[0] ^ pi[2]};
    endfunction
endpackage

module toy_scan_core
    import toy_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pi,
    input  logic       se,
    input  logic       si,
    output logic       so,
    output logic [2:0] po
);
    logic [5:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  st <= '0;
        else if (se) st <= {si, st[5:1]};
        else         st <= core_next(pi, st);
    end
    assign so = st[0];
    assign po = core_out(pi, st);
endmodule

module scan_selftest_wrap_test
    import toy_core_pkg::*;
;
    localparam int          NPAT = 12;
    localparam int          L    = 13;
    localparam logic [15:0] GOLD = 16'h0000;
    localparam logic [15:0] SEED = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  weight_mode = 2'b00;
    logic [3:0]  core_pi;
    logic [2:0]  core_po;
    logic        core_se, core_si, core_so;
    logic        busy, done, pass;
    logic [15:0] signature;

    int total = 0;
    int bad   = 0;

    logic [1:0] wsel [0:NPAT-1];

    always #10 clk = ~clk;

    scan_selftest_wrap #(
        .PI_W(4), .PO_W(3), .CORE_LEN(6), .NUM_PAT(NPAT),
        .GEN_SEED(SEED), .GOLDEN(GOLD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .weight_mode(weight_mode),
        .core_pi(core_pi), .core_po(core_po), .core_se(core_se),
        .core_si(core_si), .core_so(core_so), .busy(busy), .done(done),
        .signature(signature), .pass(pass)
    );

    toy_scan_core u_core (
        .clk(clk), .rst_n(rst_n), .pi(core_pi), .se(core_se),
        .si(core_si), .so(core_so), .po(core_po)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic gen_of(input logic [15:0] lf, input logic [1:0] w);
        case (w)
            2'b01:   return lf[15] & lf[7];
            2'b10:   return lf[15] | lf[7];
            default: return lf[15];
        endcase
    endfunction

    function automatic logic [15:0] lf_next(input logic [15:0] lf);
        return {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endfunction

    function automatic logic [15:0] sig_next(input logic [15:0] s, input logic b);
        logic fb;
        fb = s[15] ^ b;
        return {s[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // bit-serial model of the whole extended chain
    task automatic model_run(output logic [15:0] s_out, output logic [3:0] ri_out);
        logic [15:0] lf, s;
        logic [12:0] ch;
        logic [3:0]  pi;
        logic [5:0]  st;
        lf = SEED; s = '0; ch = '0;
        for (int p = 0; p < NPAT; p++) begin
            for (int i = 0; i < L; i++) begin
                if (p > 0) s = sig_next(s, ch[0]);
                ch = {gen_of(lf, wsel[p]), ch[12:1]};
                lf = lf_next(lf);
            end
            pi = ch[12:9];
            st = ch[8:3];
            ch[2:0] = core_out(pi, st);
            ch[8:3] = core_next(pi, st);
        end
        for (int i = 0; i < L; i++) begin
            s  = sig_next(s, ch[0]);
            ch = {gen_of(lf, wsel[NPAT-1]), ch[12:1]};
            lf = lf_next(lf);
        end
        s_out  = s;
        ri_out = ch[12:9];
    endtask

    task automatic run_case(input string name, input bit poke_start, output logic [15:0] got);
        int cycles, caps;
        logic [15:0] es;
        logic [3:0]  eri;
        model_run(es, eri);
        @(negedge clk);
        weight_mode = wsel[0];
        start = 1'b1;
        cycles = 0; caps = 0;
        while (cycles < 1000) begin
            @(negedge clk);
            cycles++;
            if (cycles == 1) begin
                start = 1'b0;
                check(busy == 1'b1, {name, " R10 busy after start"}, busy, 1);
            end
            if (poke_start && cycles == 40) start = 1'b1;   // R8 ignored while busy
            if (poke_start && cycles == 41) start = 1'b0;
            if (busy && !core_se) begin
                caps++;
                if (caps < NPAT) weight_mode = wsel[caps];
            end
            if (done) break;
        end
        check(done == 1'b1, {name, " R2 done reached"}, done, 1);
        check(cycles == NPAT*(L+1)+L+1, {name, " R2 run length"}, cycles, NPAT*(L+1)+L+1);
        check(caps == NPAT, {name, " R3 capture count"}, caps, NPAT);
        check(signature == es, {name, poke_start ? " R8 R6 signature" : " R6 signature"},
              signature, es);
        check(core_pi == eri, {name, " R1 source register at done"}, core_pi, eri);
        check(pass == (es == GOLD), {name, " R7 pass flag"}, pass, (es == GOLD));
        check(busy == 1'b0, {name, " R10 busy low at done"}, busy, 0);
        got = signature;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] s0, s3, sx;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(busy == 0 && done == 0 && pass == 0, "R9 reset flags", {busy, done, pass}, 0);
        check(core_se == 0, "R9 reset scan-enable", core_se, 0);
        check(signature == 0 && core_pi == 0, "R9 reset signature/pi", signature, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < NPAT; p++) wsel[p] = 2'b00;
        run_case("plain", 1'b0, s0);
        for (int p = 0; p < NPAT; p++) wsel[p] = 2'b01;
        run_case("R4 low", 1'b0, sx);
        for (int p = 0; p < NPAT; p++) wsel[p] = 2'b10;
        run_case("R4 high", 1'b0, sx);
        for (int p = 0; p < NPAT; p++) wsel[p] = 2'b11;
        run_case("R4 alt", 1'b0, s3);
        check(s3 == s0, "R4 code 11 same as 00", s3, s0);
        for (int p = 0; p < NPAT; p++) wsel[p] = 2'(p % 4);
        run_case("R5 dynamic", 1'b0, sx);
        for (int p = 0; p < NPAT; p++) wsel[p] = 2'(3 - (p % 3));
        run_case("R5 dynamic poke", 1'b1, sx);

        // R7 done and signature hold until next start
        weight_mode = 2'b01;
        repeat (6) @(negedge clk);
        check(done == 1'b1, "R7 done held", done, 1);
        check(signature == sx, "R7 signature held", signature, sx);
        check(core_se == 1'b0, "R3 scan-enable low in done", core_se, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule